// File: doc/BRIEF.md
# Dependency-Driven Episode Replay Sequencer

This block sits beside one core during deterministic replay of a multicore execution. It reads episode records from a log stream. Each record holds three things: a set of cores whose earlier episodes must finish first, a set of cores to notify when this episode finishes, and the number of memory references the episode commits. The block keeps the core stalled until every required core has signalled. It then lets the core run for exactly the recorded number of committed memory references. Finally it sends one wakeup message to each core in the notify set.

A wakeup message names only its sending core. It can arrive at any time, long before the episode that needs it. Each source core therefore has a small saturating counter of pending wakeups. A pending wakeup from a core is used by the next episode whose wait set contains that core. Because ordering comes only from these per-source counts and not from a global sequence number, episodes on different cores replay in a partial order.

Top module: `episode_replay_seq`

## Requirements
- R1: After reset, log_ready is 1 and core_run, wake_out_valid and ovf_err are 0. Every pending-wakeup counter is 0.
- R2: A record is accepted on a clock edge where log_valid and log_ready are both 1. log_ready is 1 only in the load step, so it returns to 1 only after the episode has finished its sends.
- R3: With a non-empty wait set (bit i of log_pred set means core i), core_run stays 0 until every core in the set has a pending count of at least 1. A wakeup arriving on wake_in_valid/wake_in_src adds 1 to that source's count at any time. With the counts present, core_run rises two cycles after the accept edge.
- R4: When the wait completes, one pending wakeup is taken from each core in the wait set. A wakeup from one of those cores arriving in that same cycle is still counted.
- R5: In the run step core_run is 1, and each cycle with mem_commit high counts one reference. core_run drops right after the log_refs-th commit. mem_commit is ignored outside the run step.
- R6: Wakeups go out on wake_out_valid/wake_out_dst, one per accepted handshake, in ascending core index. Exactly the cores in log_succ are sent. valid and dst are held while wake_out_ready is 0.
- R7: A record with an empty wait set skips the wait. core_run is 1 in the cycle after the accept edge.
- R8: A record with log_refs equal to 0 skips the run step and goes straight to sending. With an empty notify set as well, it returns to the load step.
- R9: A wakeup for a source whose count is already 7 sets ovf_err, which stays set until reset.
- R10: replay_done is 1 exactly when the block is in the load step, log_end is 1 and log_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| log_valid | input | 1 | Log record available |
| log_ready | output | 1 | Block accepts a record (load step) |
| log_pred | input | NUM_CORES | Wait set, one bit per core |
| log_succ | input | NUM_CORES | Notify set, one bit per core |
| log_refs | input | REFS_W | Committed memory references in the episode |
| log_end | input | 1 | Log stream exhausted |
| wake_in_valid | input | 1 | Incoming wakeup strobe |
| wake_in_src | input | CORE_W | Source core of incoming wakeup |
| core_run | output | 1 | Core may execute the episode |
| mem_commit | input | 1 | Core committed one memory reference this cycle |
| wake_out_valid | output | 1 | Outgoing wakeup valid |
| wake_out_dst | output | CORE_W | Destination core of outgoing wakeup |
| wake_out_ready | input | 1 | Interconnect takes the outgoing wakeup |
| replay_done | output | 1 | Replay on this core is complete |
| ovf_err | output | 1 | Sticky pending-counter overflow |

## Verification
A table of records is walked first. The records mix empty and full wait sets, zero and non-zero reference counts, and notify sets at the low end, high end and spread across the index range. This separates the skip paths from the normal path and tests the ascending send order at both ends. Directed cases follow:
- Wakeups sent before any record, so several episodes are covered by one source's backlog.
- A wait that stalls until a late wakeup arrives.
- A wakeup that lands in the same cycle as the consuming decrement.
- Commit pulses given during the wait.
- Send back-pressure.
- Overflow at the eighth pending wakeup.

Each case tells apart a correct count from one off by one, or from one that counts too early.

// File: rtl/episode_replay_pkg.sv
`timescale 1ns/1ps
package episode_replay_pkg;
  typedef enum logic [1:0] {PH_LOAD, PH_WAIT, PH_EXEC, PH_SEND} phase_e;

  // Step that follows a satisfied wait (or a load with an empty wait set)
  function automatic phase_e pick_after_wait(logic refs_nz, logic succ_nz);
    if (refs_nz)      return PH_EXEC;
    else if (succ_nz) return PH_SEND;
    else              return PH_LOAD;
  endfunction
endpackage

// File: rtl/rps_pending_bank.sv
`timescale 1ns/1ps
module rps_pending_bank #(
  parameter int NUM_CORES = 16,
  parameter int CNT_W     = 3,
  localparam int CORE_W   = $clog2(NUM_CORES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wake_valid,
  input  logic [CORE_W-1:0]    wake_src,
  input  logic                 consume,
  input  logic [NUM_CORES-1:0] consume_mask,
  output logic [NUM_CORES-1:0] avail,
  output logic                 ovf_err
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [NUM_CORES-1:0] hit;
  logic                 ovf_q;

  for (genvar i = 0; i < NUM_CORES; i++) begin : g_src
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             inc, dec;

    assign inc = wake_valid && (wake_src == CORE_W'(i));
    assign dec = consume && consume_mask[i];

    always_comb begin
      cnt_d  = cnt_q;
      hit[i] = 1'b0;
      if (inc && !dec) begin
        if (cnt_q == CNT_MAX) hit[i] = 1'b1;
        else                  cnt_d  = cnt_q + CNT_W'(1);
      end else if (dec && !inc) begin
        cnt_d = cnt_q - CNT_W'(1);
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt_q <= '0;
      else if (inc || dec)  cnt_q <= cnt_d;
    end

    assign avail[i] = (cnt_q != '0);

    // R4: a consumed credit with no simultaneous arrival lowers the count by one
    p_consume_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (dec && !inc) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
    // R4: consume plus arrival in the same cycle leaves the count unchanged
    p_same_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (dec && inc) |=> $stable(cnt_q));
    // R9: arrival at a full counter raises the error flag
    p_ovf_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !dec && cnt_q == CNT_MAX) |=> ovf_err);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ovf_q <= 1'b0;
    else if (|hit) ovf_q <= 1'b1;
  end

  assign ovf_err = ovf_q;

  // R9: the error flag never clears outside reset
  p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q);
endmodule

// File: rtl/rps_ref_counter.sv
`timescale 1ns/1ps
module rps_ref_counter #(
  parameter int REFS_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [REFS_W-1:0] load_val,
  input  logic              dec,
  output logic              nz,
  output logic              last
);
  logic [REFS_W-1:0] left_q, left_d;

  always_comb begin
    left_d = left_q;
    if (load)     left_d = load_val;
    else if (dec) left_d = left_q - REFS_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           left_q <= '0;
    else if (load || dec) left_q <= left_d;
  end

  assign nz   = (left_q != '0);
  assign last = (left_q == REFS_W'(1));

  // R5: each counted commit removes exactly one reference
  p_refs_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !load) |=> (left_q == $past(left_q) - REFS_W'(1)));
endmodule

// File: rtl/rps_succ_issuer.sv
`timescale 1ns/1ps
module rps_succ_issuer #(
  parameter int NUM_CORES = 16,
  localparam int CORE_W   = $clog2(NUM_CORES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic [NUM_CORES-1:0] load_mask,
  input  logic                 active,
  input  logic                 ready,
  output logic                 valid,
  output logic [CORE_W-1:0]    dst,
  output logic                 pending,
  output logic                 last
);
  logic [NUM_CORES-1:0] rem_q, rem_d, low_oh;
  logic                 pop;

  assign low_oh  = rem_q & (~rem_q + NUM_CORES'(1));
  assign pending = |rem_q;
  assign last    = ((rem_q & ~low_oh) == '0);
  assign valid   = active && pending;
  assign pop     = valid && ready;

  always_comb begin
    dst = '0;
    for (int k = NUM_CORES - 1; k >= 0; k--) begin
      if (rem_q[k]) dst = CORE_W'(k);
    end
  end

  always_comb begin
    rem_d = rem_q;
    if (load)     rem_d = load_mask;
    else if (pop) rem_d = rem_q & ~low_oh;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           rem_q <= '0;
    else if (load || pop) rem_q <= rem_d;
  end

  // R6: a sent destination is removed and never sent again in the episode
  p_pop_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !load) |=> !rem_q[$past(dst)]);
endmodule

// File: rtl/episode_replay_seq.sv
`timescale 1ns/1ps
module episode_replay_seq
  import episode_replay_pkg::*;
#(
  parameter int NUM_CORES = 16,
  parameter int CNT_W     = 3,
  parameter int REFS_W    = 16,
  localparam int CORE_W   = $clog2(NUM_CORES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 log_valid,
  output logic                 log_ready,
  input  logic [NUM_CORES-1:0] log_pred,
  input  logic [NUM_CORES-1:0] log_succ,
  input  logic [REFS_W-1:0]    log_refs,
  input  logic                 log_end,
  input  logic                 wake_in_valid,
  input  logic [CORE_W-1:0]    wake_in_src,
  output logic                 core_run,
  input  logic                 mem_commit,
  output logic                 wake_out_valid,
  output logic [CORE_W-1:0]    wake_out_dst,
  input  logic                 wake_out_ready,
  output logic                 replay_done,
  output logic                 ovf_err
);
  phase_e               phase_q, phase_d;
  logic [NUM_CORES-1:0] pred_q;
  logic [NUM_CORES-1:0] avail;
  logic                 accept, preds_met, consume, commit_cnt;
  logic                 refs_nz, refs_last;
  logic                 succ_pending, succ_last;

  assign accept     = log_valid && log_ready;
  assign preds_met  = &(avail | ~pred_q);
  assign consume    = (phase_q == PH_WAIT) && preds_met;
  assign commit_cnt = (phase_q == PH_EXEC) && mem_commit;

  rps_pending_bank #(.NUM_CORES(NUM_CORES), .CNT_W(CNT_W)) u_bank (
    .clk, .rst_n,
    .wake_valid   (wake_in_valid),
    .wake_src     (wake_in_src),
    .consume      (consume),
    .consume_mask (pred_q),
    .avail        (avail),
    .ovf_err      (ovf_err)
  );

  rps_ref_counter #(.REFS_W(REFS_W)) u_refs (
    .clk, .rst_n,
    .load     (accept),
    .load_val (log_refs),
    .dec      (commit_cnt),
    .nz       (refs_nz),
    .last     (refs_last)
  );

  rps_succ_issuer #(.NUM_CORES(NUM_CORES)) u_issue (
    .clk, .rst_n,
    .load      (accept),
    .load_mask (log_succ),
    .active    (phase_q == PH_SEND),
    .ready     (wake_out_ready),
    .valid     (wake_out_valid),
    .dst       (wake_out_dst),
    .pending   (succ_pending),
    .last      (succ_last)
  );

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_LOAD: if (log_valid)
                 phase_d = (log_pred != '0) ? PH_WAIT
                         : pick_after_wait(log_refs != '0, log_succ != '0);
      PH_WAIT: if (preds_met)
                 phase_d = pick_after_wait(refs_nz, succ_pending);
      PH_EXEC: if (mem_commit && refs_last)
                 phase_d = succ_pending ? PH_SEND : PH_LOAD;
      PH_SEND: if (wake_out_ready && succ_last)
                 phase_d = PH_LOAD;
      default: phase_d = PH_LOAD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_LOAD;
    else        phase_q <= phase_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pred_q <= '0;
    else if (accept) pred_q <= log_pred;
  end

  assign log_ready   = (phase_q == PH_LOAD);
  assign core_run    = (phase_q == PH_EXEC);
  assign replay_done = (phase_q == PH_LOAD) && log_end && !log_valid;

  // R2: a record with a non-empty wait set always enters the wait step
  p_accept_wait_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && log_pred != '0) |=> (phase_q == PH_WAIT));
  // R3: the core is held while any required wakeup is missing
  p_wait_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_WAIT && !preds_met) |=> !core_run);
  // R5: without a commit the run step continues
  p_exec_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (core_run && !mem_commit) |=> core_run);
  // R6: a stalled wakeup keeps its destination
  p_send_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_out_valid && !wake_out_ready) |=> (wake_out_valid && $stable(wake_out_dst)));
  // R7: an empty wait set with work to do starts running at once
  p_skip_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && log_pred == '0 && log_refs != '0) |=> core_run);
endmodule

// File: tb/episode_replay_seq_tb_top.sv
`timescale 1ns/1ps
module episode_replay_seq_tb_top;
  localparam int N  = 16;
  localparam int CW = 4;
  localparam int RW = 16;

  typedef struct packed {
    logic [15:0] pre;
    logic [15:0] pred;
    logic [15:0] succ;
    logic [7:0]  refs;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{16'h0000, 16'h0000, 16'h0005, 8'd3},
    '{16'h0002, 16'h0002, 16'h8000, 8'd1},
    '{16'h0108, 16'h0108, 16'h0000, 8'd4},
    '{16'h8001, 16'h8001, 16'h00F0, 8'd2},
    '{16'h0000, 16'h0000, 16'h0300, 8'd0},
    '{16'h0040, 16'h0040, 16'h0000, 8'd0}
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          log_valid, log_ready, log_end;
  logic [N-1:0]  log_pred, log_succ;
  logic [RW-1:0] log_refs;
  logic          wake_in_valid;
  logic [CW-1:0] wake_in_src;
  logic          core_run, mem_commit;
  logic          wake_out_valid, wake_out_ready;
  logic [CW-1:0] wake_out_dst;
  logic          replay_done, ovf_err;

  int n_checks = 0;
  int n_fail   = 0;

  always #10 clk = ~clk;

  episode_replay_seq #(.NUM_CORES(N), .CNT_W(3), .REFS_W(RW)) dut_i (
    .clk, .rst_n, .log_valid, .log_ready, .log_pred, .log_succ, .log_refs,
    .log_end, .wake_in_valid, .wake_in_src, .core_run, .mem_commit,
    .wake_out_valid, .wake_out_dst, .wake_out_ready, .replay_done, .ovf_err
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send_wake(int src);
    wake_in_valid = 1'b1;
    wake_in_src   = CW'(src);
    tick();
    wake_in_valid = 1'b0;
  endtask

  task automatic push_record(logic [N-1:0] p, logic [N-1:0] s, int r);
    chk("R2 ready before accept", log_ready, 1);
    log_valid = 1'b1;
    log_pred  = p;
    log_succ  = s;
    log_refs  = RW'(r);
    tick();
    log_valid = 1'b0;
  endtask

  task automatic commit_all(int r);
    for (int k = 0; k < r; k++) begin
      chk("R5 running before commit", core_run, 1);
      mem_commit = 1'b1;
      tick();
      mem_commit = 1'b0;
    end
    chk("R5 stop after last commit", core_run, 0);
  endtask

  task automatic collect(logic [N-1:0] s, string tag);
    logic [N-1:0] got = '0;
    int prev = -1;
    for (int k = 0; k < N + 2 && wake_out_valid; k++) begin
      chk({tag, " R6 ascending"}, (int'(wake_out_dst) > prev), 1);
      prev = int'(wake_out_dst);
      got[wake_out_dst] = 1'b1;
      tick();
    end
    chk({tag, " R6 sent set"}, got, s);
  endtask

  task automatic run_vec(vec_t v);
    for (int k = 0; k < N; k++) if (v.pre[k]) send_wake(k);
    push_record(v.pred, v.succ, int'(v.refs));
    if (v.pred != '0) begin
      chk("R3 wait cycle", core_run | wake_out_valid, 0);
      tick();
    end
    if (v.refs != '0) begin
      chk((v.pred == '0) ? "R7 skip wait" : "R3 R4 start", core_run, 1);
      commit_all(int'(v.refs));
    end else if (v.succ != '0) begin
      chk("R8 straight to send", wake_out_valid, 1);
      chk("R8 no run", core_run, 0);
    end
    collect(v.succ, "vec");
    chk("R2 R8 back to load", log_ready, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; log_valid = 1'b0; log_pred = '0; log_succ = '0; log_refs = '0;
    log_end = 1'b0; wake_in_valid = 1'b0; wake_in_src = '0; mem_commit = 1'b0;
    wake_out_ready = 1'b1;
    tick(); tick();
    rst_n = 1'b1;
    tick();

    // R1 reset state
    chk("R1 log_ready", log_ready, 1);
    chk("R1 core_run", core_run, 0);
    chk("R1 wake_out_valid", wake_out_valid, 0);
    chk("R1 ovf_err", ovf_err, 0);

    // Table of records
    foreach (VECS[i]) run_vec(VECS[i]);

    // R3: backlog of two wakeups from core 2 covers two episodes
    send_wake(2); send_wake(2);
    run_vec('{16'h0000, 16'h0004, 16'h0000, 8'd1});
    run_vec('{16'h0000, 16'h0004, 16'h0000, 8'd1});

    // R3 + R5: stall until a late wakeup; commits during the wait ignored
    push_record(16'h0004, 16'h0000, 2);
    mem_commit = 1'b1;
    repeat (8) tick();
    mem_commit = 1'b0;
    chk("R3 stalled without wakeup", core_run, 0);
    chk("R2 not ready while waiting", log_ready, 0);
    send_wake(2);
    chk("R3 one cycle to take wakeup", core_run, 0);
    tick();
    chk("R3 released", core_run, 1);
    mem_commit = 1'b1; tick(); mem_commit = 1'b0;
    tick();
    chk("R5 idle cycle keeps running", core_run, 1);
    commit_all(1);

    // R4: wakeup arriving in the consuming cycle is kept
    send_wake(6);
    log_valid = 1'b1; log_pred = 16'h0040; log_succ = '0; log_refs = RW'(1);
    tick();
    log_valid = 1'b0;
    wake_in_valid = 1'b1; wake_in_src = CW'(6);
    tick();
    wake_in_valid = 1'b0;
    chk("R4 first consumer runs", core_run, 1);
    commit_all(1);
    run_vec('{16'h0000, 16'h0040, 16'h0000, 8'd1});

    // R6: back-pressure holds the message
    wake_out_ready = 1'b0;
    push_record(16'h0000, 16'h0A00, 0);
    repeat (3) tick();
    chk("R6 held valid", wake_out_valid, 1);
    chk("R6 held dst", wake_out_dst, 9);
    wake_out_ready = 1'b1;
    tick();
    chk("R6 next dst", wake_out_dst, 11);
    tick();
    chk("R6 done sending", wake_out_valid, 0);

    // R10: completion flag
    log_end = 1'b1;
    tick();
    chk("R10 done when idle", replay_done, 1);
    log_end = 1'b0;
    push_record(16'h0000, 16'h0000, 1);
    log_end = 1'b1;
    chk("R10 not done while running", replay_done, 0);
    commit_all(1);
    chk("R10 done after episode", replay_done, 1);
    log_end = 1'b0;

    // R9: eighth pending wakeup overflows
    for (int k = 0; k < 7; k++) send_wake(9);
    chk("R9 seven pending fine", ovf_err, 0);
    send_wake(9);
    chk("R9 overflow raised", ovf_err, 1);
    repeat (3) tick();
    chk("R9 overflow sticky", ovf_err, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule